// File: doc/BRIEF.md
# DMA Audio Replay Engine

This block plays 8-bit audio samples straight out of memory. Software writes a 24-bit frame start address and a 24-bit frame end address, one byte per register. It also sets a mode byte that selects mono or stereo and one of four sample rates. Software then sets the run bit. The engine fetches one byte per mono sample, or two bytes per stereo pair, through a request/grant read port. A programmable divider of the system clock paces these fetches, and the fetched bytes appear on separate left and right sample outputs.

The frame runs from the start address up to, but not including, the end address. When the fetch address reaches the end address, the engine pulses a frame interrupt. With repeat set it carries on from the start address in the same cycle. Without repeat it clears its run bit and stops. Software can read back the live fetch address at any time, and can stop playback at any point by writing zero to the control register.

Top module: `pcm_replay_dma`

## Requirements
- R1: After reset, mem_req, smp_valid and frame_irq are low, both sample outputs are zero, and the control and current-address registers read zero.
- R2: Register offsets are: 2/3/4 start address bits [23:16]/[15:8]/[7:0], and 5/6/7 end address bits [23:16]/[15:8]/[7:0]. Each of these registers reads back the byte last written to it.
- R3: Writing the control register (offset 0) with bit 0 set while the engine is idle copies the start and end registers into working registers, and the first fetch uses the start address. A start or end register write made during playback takes effect only when the frame next restarts.
- R4: The mode register is at offset 1, with rate in bits [1:0]. While running, a fetch tick occurs every BASE_DIV·2^(3−rate) clock cycles, so rate 3 is the fastest and rate 0 the slowest. Each fetch set then completes at that same spacing.
- R5: With mode bit 7 set (mono), a tick causes exactly one fetch, and the byte drives both smp_left and smp_right.
- R6: With mode bit 7 clear (stereo), a tick causes two fetches. A byte from an even address drives smp_left and a byte from an odd address drives smp_right. smp_valid pulses for one cycle after the last fetch of each set.
- R7: When a granted fetch moves the address onto the end address, frame_irq pulses high for one cycle.
- R8: When control bit 1 (repeat) is set at the end of a frame, the current address is reloaded from the start register in that same cycle, and playback continues with no idle tick.
- R9: When repeat is clear at the end of a frame, the run bit (control bit 0 on read-back) clears and no further requests are made.
- R10: Writing the control register with bit 0 clear stops playback, and mem_req is low from the next cycle.
- R11: The sample outputs change only on a granted fetch. A tick that arrives while a fetch set is still waiting for grant is dropped.
- R12: Offsets 8/9/10 read the live fetch address bits [23:16]/[15:8]/[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Memory byte address |
| mem_gnt | input | 1 | Memory grant; data is valid in the same cycle |
| mem_rdata | input | 8 | Memory read data |
| smp_left | output | 8 | Left channel sample |
| smp_right | output | 8 | Right channel sample |
| smp_valid | output | 1 | One-cycle pulse when a sample set completes |
| frame_irq | output | 1 | One-cycle end-of-frame interrupt |

## Verification
The bench steers a stereo frame with repeat into a second frame whose start and end were rewritten mid-playback. A design that applied those writes at once, or that reloaded late, would fetch from the wrong address or leave a one-tick hole at the seam. It also starves the grant so that ticks must be dropped. A design that queued those ticks, or that changed its outputs without a grant, would disagree with the reference model cycle by cycle. Finally, it checks that a non-repeating frame halts with the run bit clear and the address parked on the end value, and that the slowest rate spaces completed samples exactly 64 cycles apart.

// File: rtl/pcm_replay_pkg.sv
package pcm_replay_pkg;

  localparam int ADDR_W     = 24;
  localparam int SMP_W      = 8;
  localparam int ADDR_BYTES = ADDR_W / 8;

  // register offsets
  localparam logic [3:0] SEL_CTRL    = 4'd0;
  localparam logic [3:0] SEL_MODE    = 4'd1;
  localparam logic [3:0] SEL_START_H = 4'd2;
  localparam logic [3:0] SEL_START_L = 4'd4;
  localparam logic [3:0] SEL_END_L   = 4'd7;
  localparam logic [3:0] SEL_CUR_L   = 4'd10;

  // control bit positions
  localparam int CTRL_RUN = 0;
  localparam int CTRL_REP = 1;
  localparam int MODE_MONO = 7;

  // clock cycles between fetch ticks for a rate code (3 = fastest)
  function automatic int unsigned tick_period(int unsigned base, logic [1:0] rate);
    return base << (2'd3 - rate);
  endfunction

  // number of memory fetches one tick asks for
  function automatic logic [1:0] fetches_per_tick(logic mono);
    return mono ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/pr_regs.sv
module pr_regs
  import pcm_replay_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              run,
  input  logic              rep,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] end_addr,
  output logic              mono,
  output logic [1:0]        rate,
  output logic              ctrl_wr,
  output logic [7:0]        reg_rdata
);

  assign ctrl_wr = reg_wr && (reg_addr == SEL_CTRL);

  // one register pair per address byte, low byte has the highest offset
  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
    localparam logic [3:0] S_SEL = SEL_START_L - 4'(b);
    localparam logic [3:0] E_SEL = SEL_END_L - 4'(b);
    logic [7:0] s_q, e_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= '0;
        e_q <= '0;
      end else if (reg_wr) begin
        if (reg_addr == S_SEL) s_q <= reg_wdata;
        if (reg_addr == E_SEL) e_q <= reg_wdata;
      end
    end
    assign start_addr[b*8 +: 8] = s_q;
    assign end_addr[b*8 +: 8]   = e_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mono <= 1'b0;
      rate <= 2'd0;
    end else if (reg_wr && reg_addr == SEL_MODE) begin
      mono <= reg_wdata[MODE_MONO];
      rate <= reg_wdata[1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == SEL_CTRL) reg_rdata = {6'd0, rep, run};
    if (reg_addr == SEL_MODE) reg_rdata = {mono, 5'd0, rate};
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (reg_addr == SEL_START_L - 4'(b)) reg_rdata = start_addr[b*8 +: 8];
      if (reg_addr == SEL_END_L - 4'(b))   reg_rdata = end_addr[b*8 +: 8];
      if (reg_addr == SEL_CUR_L - 4'(b))   reg_rdata = cur_addr[b*8 +: 8];
    end
  end

  assert_start_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == SEL_START_H) |=> (start_addr[ADDR_W-1 -: 8] == $past(reg_wdata)));

endmodule

// File: rtl/pr_rate_gen.sv
module pr_rate_gen
  import pcm_replay_pkg::*;
#(
  parameter int BASE_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);

  localparam int MAX_PERIOD = BASE_DIV * 8;
  localparam int CW = $clog2(MAX_PERIOD + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;

  assign reload = CW'(tick_period(BASE_DIV, rate) - 1);
  assign tick   = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= reload;
    else if (tick) cnt <= reload;
    else           cnt <= cnt - 1'b1;
  end

  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reload != '0) |=> !tick);

endmodule

// File: rtl/pr_fetch.sv
module pr_fetch
  import pcm_replay_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ctrl_run,
  input  logic              ctrl_rep,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic              mono,
  input  logic              tick,
  input  logic              mem_gnt,
  input  logic [SMP_W-1:0]  mem_rdata,
  output logic              run,
  output logic              rep,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SMP_W-1:0]  smp_left,
  output logic [SMP_W-1:0]  smp_right,
  output logic              smp_valid,
  output logic              frame_irq
);

  logic [ADDR_W-1:0] end_w;
  logic [1:0]        need;
  logic              fire, hit_end, start_evt, stop_evt, to_left, to_right;
  logic [ADDR_W-1:0] nxt;

  assign mem_req   = run && (need != 2'd0);
  assign mem_addr  = cur_addr;
  assign fire      = mem_req && mem_gnt;
  assign nxt       = cur_addr + ADDR_W'(1);
  assign hit_end   = fire && (nxt == end_w);
  assign start_evt = ctrl_wr && ctrl_run && !run;
  assign stop_evt  = ctrl_wr && !ctrl_run;
  assign to_left   = mono || !cur_addr[0];
  assign to_right  = mono || cur_addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      rep       <= 1'b0;
      cur_addr  <= '0;
      end_w     <= '0;
      need      <= 2'd0;
      smp_left  <= '0;
      smp_right <= '0;
      smp_valid <= 1'b0;
      frame_irq <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      frame_irq <= 1'b0;
      if (fire) begin
        if (to_left)  smp_left  <= mem_rdata;
        if (to_right) smp_right <= mem_rdata;
        smp_valid <= (need == 2'd1);
        need      <= need - 2'd1;
        cur_addr  <= nxt;
        if (hit_end) begin
          frame_irq <= 1'b1;
          if (rep) begin
            cur_addr <= start_addr;
            end_w    <= end_addr;
          end else begin
            run  <= 1'b0;
            need <= 2'd0;
          end
        end
      end else if (tick && need == 2'd0) begin
        need <= fetches_per_tick(mono);
      end
      if (ctrl_wr) begin
        rep <= ctrl_rep;
        if (start_evt) begin
          run      <= 1'b1;
          cur_addr <= start_addr;
          end_w    <= end_addr;
          need     <= 2'd0;
        end else if (stop_evt) begin
          run  <= 1'b0;
          need <= 2'd0;
        end
      end
    end
  end

  assert_begin_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (run && cur_addr == $past(start_addr)));
  assert_valid_from_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(fire));
  assert_irq_from_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> $past(fire));
  assert_seamless_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_end && rep && !ctrl_wr) |=> (run && cur_addr == $past(start_addr)));
  assert_halt_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_end && !rep && !ctrl_wr) |=> (!run && !mem_req));
  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !mem_req);
  assert_hold_without_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(smp_left) && $stable(smp_right)));

endmodule

// File: rtl/pcm_replay_dma.sv
module pcm_replay_dma
  import pcm_replay_pkg::*;
#(
  parameter int BASE_DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        mem_req,
  output logic [23:0] mem_addr,
  input  logic        mem_gnt,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  smp_left,
  output logic [7:0]  smp_right,
  output logic        smp_valid,
  output logic        frame_irq
);

  logic [ADDR_W-1:0] start_addr, end_addr, cur_addr;
  logic              mono, run, rep, ctrl_wr, tick;
  logic [1:0]        rate;

  pr_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .run        (run),
    .rep        (rep),
    .cur_addr   (cur_addr),
    .start_addr (start_addr),
    .end_addr   (end_addr),
    .mono       (mono),
    .rate       (rate),
    .ctrl_wr    (ctrl_wr),
    .reg_rdata  (reg_rdata)
  );

  pr_rate_gen #(.BASE_DIV(BASE_DIV)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .rate  (rate),
    .tick  (tick)
  );

  pr_fetch u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_run   (reg_wdata[CTRL_RUN]),
    .ctrl_rep   (reg_wdata[CTRL_REP]),
    .start_addr (start_addr),
    .end_addr   (end_addr),
    .mono       (mono),
    .tick       (tick),
    .mem_gnt    (mem_gnt),
    .mem_rdata  (mem_rdata),
    .run        (run),
    .rep        (rep),
    .cur_addr   (cur_addr),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .smp_left   (smp_left),
    .smp_right  (smp_right),
    .smp_valid  (smp_valid),
    .frame_irq  (frame_irq)
  );

endmodule

// File: tb/pcm_replay_dma_test.sv
module pcm_replay_dma_test;
  localparam int BASE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic        mem_gnt = 1'b0;
  wire  [7:0]  reg_rdata;
  wire         mem_req;
  wire  [23:0] mem_addr;
  wire  [7:0]  mem_rdata;
  wire  [7:0]  smp_left, smp_right;
  wire         smp_valid, frame_irq;

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction
  assign mem_rdata = mem_byte(mem_addr);

  pcm_replay_dma #(.BASE_DIV(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid),
    .frame_irq(frame_irq)
  );

  int    errs = 0, checks = 0, stall_n = 1, gcount = 0, cyc = 0, irq_cnt = 0, vcnt = 0;
  bit    done = 1'b0;
  string ph = "R1";

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_run, m_rep, m_mono, m_rate, m_need, m_cnt, m_start, m_endr, m_endw, m_cur;
  int m_left, m_right, m_valid, m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_rep = 0; m_mono = 0; m_rate = 0; m_need = 0; m_cnt = 0;
      m_start = 0; m_endr = 0; m_endw = 0; m_cur = 0;
      m_left = 0; m_right = 0; m_valid = 0; m_irq = 0;
    end else begin
      int per, was_run, d;
      bit tk, fr;
      per     = BASE << (3 - m_rate);
      was_run = m_run;
      tk      = (m_run != 0) && (m_cnt == per - 1);
      fr      = (m_run != 0) && (m_need > 0) && mem_gnt;
      if (m_run == 0 || tk) m_cnt = 0; else m_cnt++;
      m_valid = 0; m_irq = 0;
      if (fr) begin
        d = int'(mem_byte(24'(m_cur)));
        if (m_mono != 0) begin m_left = d; m_right = d; end
        else if (m_cur % 2 == 1) m_right = d;
        else m_left = d;
        m_valid = (m_need == 1) ? 1 : 0;
        m_need--;
        m_cur = (m_cur + 1) % (1 << 24);
        if (m_cur == m_endw) begin
          m_irq = 1;
          if (m_rep != 0) begin m_cur = m_start; m_endw = m_endr; end
          else begin m_run = 0; m_need = 0; end
        end
      end else if (tk && m_need == 0) begin
        m_need = (m_mono != 0) ? 1 : 2;
      end
      if (reg_wr) begin
        case (reg_addr)
          4'd0: begin
            m_rep = int'(reg_wdata[1]);
            if (reg_wdata[0] && was_run == 0) begin
              m_run = 1; m_cur = m_start; m_endw = m_endr; m_need = 0;
            end else if (!reg_wdata[0]) begin
              m_run = 0; m_need = 0;
            end
          end
          4'd1: begin m_mono = int'(reg_wdata[7]); m_rate = int'(reg_wdata[1:0]); end
          4'd2: m_start = (m_start & 32'h00FFFF) | (int'(reg_wdata) << 16);
          4'd3: m_start = (m_start & 32'hFF00FF) | (int'(reg_wdata) << 8);
          4'd4: m_start = (m_start & 32'hFFFF00) | int'(reg_wdata);
          4'd5: m_endr  = (m_endr & 32'h00FFFF) | (int'(reg_wdata) << 16);
          4'd6: m_endr  = (m_endr & 32'hFF00FF) | (int'(reg_wdata) << 8);
          4'd7: m_endr  = (m_endr & 32'hFFFF00) | int'(reg_wdata);
          default: ;
        endcase
      end
    end
  end

  // memory grant: immediate, or only every stall_n-th cycle
  always @(negedge clk) begin
    gcount++;
    mem_gnt = mem_req && (stall_n <= 1 || gcount % stall_n == 0);
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      bit mreq;
      mreq = (m_run != 0) && (m_need > 0);
      chk(ph, "mem_req", mem_req, mreq);
      if (mreq) chk(ph, "mem_addr", mem_addr, m_cur);
      chk(ph, "smp_left", smp_left, m_left);
      chk(ph, "smp_right", smp_right, m_right);
      chk(ph, "smp_valid", smp_valid, m_valid);
      chk(ph, "frame_irq", frame_irq, m_irq);
      if (frame_irq) irq_cnt++;
      if (smp_valid) vcnt++;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_now(input logic [3:0] a, input longint exp, input string tag, input string what);
    reg_addr = a;
    #1;
    chk(tag, what, reg_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "mem_req", mem_req, 0);
    chk("R1", "smp_valid", smp_valid, 0);
    chk("R1", "frame_irq", frame_irq, 0);
    chk("R1", "samples", {smp_left, smp_right}, 0);
    rd_now(4'd0, 0, "R1", "ctrl");
    rd_now(4'd10, 0, "R1", "cur low");
    rst_n = 1'b1;

    // R2: byte-split start and end registers
    ph = "R2";
    wr(4'd2, 8'h00); wr(4'd3, 8'h10); wr(4'd4, 8'h00);
    wr(4'd5, 8'h00); wr(4'd6, 8'h10); wr(4'd7, 8'h06);
    @(negedge clk);
    rd_now(4'd3, 8'h10, "R2", "start mid");
    rd_now(4'd4, 8'h00, "R2", "start low");
    rd_now(4'd6, 8'h10, "R2", "end mid");
    rd_now(4'd7, 8'h06, "R2", "end low");

    // R5/R7/R9/R12: mono, fastest rate, single frame
    ph = "R5";
    wr(4'd1, 8'h83);
    irq_cnt = 0;
    wr(4'd0, 8'h01);
    repeat (100) @(negedge clk);
    chk("R7", "irq count for one frame", irq_cnt, 1);
    chk("R5", "mono channels equal", smp_left, smp_right);
    rd_now(4'd0, 0, "R9", "ctrl after frame end");
    rd_now(4'd9, 8'h10, "R12", "cur mid parked");
    rd_now(4'd10, 8'h06, "R12", "cur low parked");

    // R3/R8: stereo with repeat, new frame written mid-playback
    ph = "R3";
    wr(4'd1, 8'h02);
    wr(4'd0, 8'h03);
    wr(4'd2, 8'h00); wr(4'd3, 8'h20); wr(4'd4, 8'h00);
    wr(4'd5, 8'h00); wr(4'd6, 8'h20); wr(4'd7, 8'h04);
    do @(negedge clk); while (!frame_irq);
    rd_now(4'd9, 8'h20, "R3", "cur mid after restart");
    rd_now(4'd10, 8'h00, "R3", "cur low after restart");
    rd_now(4'd0, 3, "R8", "still running with repeat");

    // R6: repeated stereo frames
    ph = "R6";
    repeat (200) @(negedge clk);
    rd_now(4'd10, m_cur & 8'hFF, "R12", "live cur low");
    rd_now(4'd9, (m_cur >> 8) & 8'hFF, "R12", "live cur mid");

    // R10: stop by writing zero
    ph = "R10";
    wr(4'd0, 8'h00);
    #1 chk("R10", "mem_req after stop", mem_req, 0);

    // R11: starved grant, ticks dropped
    ph = "R11";
    stall_n = 50;
    wr(4'd1, 8'h83);
    vcnt = 0;
    wr(4'd0, 8'h03);
    repeat (600) @(negedge clk);
    chk("R11", "samples paced by grant", (vcnt >= 4 && vcnt <= 14), 1);
    wr(4'd0, 8'h00);
    stall_n = 1;

    // R4: slowest rate spacing
    ph = "R4";
    wr(4'd1, 8'h80);
    wr(4'd0, 8'h03);
    begin
      int t0;
      do @(negedge clk); while (!smp_valid);
      t0 = cyc;
      do @(negedge clk); while (!smp_valid);
      chk("R4", "cycles between samples at rate 0", cyc - t0, BASE * 8);
    end
    wr(4'd0, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL %s watchdog actual=timeout expected=finished", ph);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule